// File: doc/BRIEF.md
# Block Memory Copy and Search Sequencer

This block is a small sequencer that moves bytes from one memory region to another, or scans a region for a byte value. It is loaded with a 16-bit source pointer, a 16-bit destination pointer, a 16-bit byte count and an 8-bit key. An 8-bit operation code then selects three things:

- copy or search;
- walking the pointers upward or downward;
- a single step, or repeating until the work is done.

The sequencer issues one byte access at a time on a simple request/acknowledge memory port. After every byte it updates its pointers and its count.

A copy step reads the byte at the source pointer and writes it at the destination pointer. It then moves both pointers one place in the selected direction and decrements the count. A search step reads the byte at the source pointer and compares it with the key. It then moves the source pointer and decrements the count. The destination pointer is left alone and nothing is written.

The repeating forms run until the count reaches zero. A repeating search also stops on the first byte that equals the key. A starting count of zero wraps, so 65536 bytes are processed. When the operation ends, the final pointers, the count, a count-not-zero flag and a key-match flag are available at the outputs, and a one-cycle completion pulse is given.

Top module: `blkx_engine`

## Requirements
- R1: When `start` is high in a cycle where `busy` is low and the operation code is valid, the pointers, count and key are loaded and `busy` is high from the next cycle. A `start` while `busy` is high has no effect on the running operation.
- R2: Operation code fields:
  - A code is valid only when bits 7:5 are 101 and bits 2:1 are 00.
  - Bit 0 = 1 selects search and 0 selects copy.
  - Bit 3 = 1 selects downward and 0 selects upward.
  - Bit 4 = 1 selects repeat and 0 selects single.
  - A `start` with an invalid code is ignored: `busy` stays low and the outputs keep their values.
- R3: A copy step makes one read at the source pointer (`mem_we`=0), followed by one write (`mem_we`=1) of the same byte at the destination pointer.
- R4: After each completed step:
  - the count is decremented by one, wrapping;
  - the source pointer moves by one place (up or down, per bit 3), wrapping;
  - on a copy, the destination pointer moves the same way.
- R5: A search step makes exactly one read and no write, leaves the destination pointer unchanged, and sets `match` to whether the byte read equals the key.
- R6: A single form performs exactly one step.
- R7: A repeat form keeps stepping until the count reaches zero. A starting count of zero processes 65536 bytes.
- R8: A repeating search stops after the step whose byte equals the key, with `match` high.
- R9: A memory request holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`. The access completes in a cycle where `mem_req` and `mem_ack` are both high.
- R10: Status outputs:
  - `done` is high for exactly one cycle, in the first cycle where `busy` is low again.
  - `cnt_nz` equals (`cnt_out` != 0).
  - `match` is cleared at each start and stays low for a copy.
- R11: After reset, `busy`, `done`, `mem_req`, `match` and all pointer and count outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request |
| op_code | input | 8 | Operation code |
| src_init | input | 16 | Starting source pointer |
| dst_init | input | 16 | Starting destination pointer |
| cnt_init | input | 16 | Starting byte count |
| key | input | 8 | Search value |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Operation running |
| done | output | 1 | One-cycle completion pulse |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current byte count |
| cnt_nz | output | 1 | Count is not zero |
| match | output | 1 | Last searched byte equalled the key |

## Verification
Some behaviour is checked by assertions on every cycle:
- the per-step updates of the count and pointers in both directions;
- the destination pointer staying frozen during a search;
- the read-then-write pairing of a copy;
- request stability while an access is stalled;
- the early stop on a key hit;
- the stop after a single step;
- the rejection of invalid codes;
- the placement of the completion pulse.

Other behaviour only the bench scenarios can show: that the bytes land at the right addresses in overlapping and random regions, that repeat runs stop at the right count, that a zero count really walks all 65536 bytes, and that a second `start` during a run leaves its result intact.

// File: rtl/blkx_pkg.sv
`timescale 1ns/1ps
package blkx_pkg;
    localparam int          OP_CMP_BIT = 0;
    localparam int          OP_DIR_BIT = 3;
    localparam int          OP_RPT_BIT = 4;
    localparam logic [2:0]  OP_GROUP   = 3'b101;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } blkx_state_e;

    typedef struct packed {
        logic valid;
        logic cmp;
        logic down;
        logic rpt;
    } blkx_op_t;
endpackage

// File: rtl/blkx_decode.sv
`timescale 1ns/1ps
module blkx_decode
    import blkx_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic [OPW-1:0] op_code,
    output blkx_op_t       op
);
    always_comb begin
        op.cmp   = op_code[OP_CMP_BIT];
        op.down  = op_code[OP_DIR_BIT];
        op.rpt   = op_code[OP_RPT_BIT];
        op.valid = (op_code[OPW-1 -: 3] == OP_GROUP) && (op_code[2:1] == 2'b00);
    end
endmodule

// File: rtl/blkx_step.sv
`timescale 1ns/1ps
module blkx_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         down,
    output logic [W-1:0] nxt
);
    always_comb nxt = down ? (val - W'(1)) : (val + W'(1));
endmodule

// File: rtl/blkx_engine.sv
`timescale 1ns/1ps
module blkx_engine
    import blkx_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int CW  = 16,
    parameter int OPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [OPW-1:0] op_code,
    input  logic [AW-1:0]  src_init,
    input  logic [AW-1:0]  dst_init,
    input  logic [CW-1:0]  cnt_init,
    input  logic [DW-1:0]  key,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    output logic           busy,
    output logic           done,
    output logic [AW-1:0]  src_out,
    output logic [AW-1:0]  dst_out,
    output logic [CW-1:0]  cnt_out,
    output logic           cnt_nz,
    output logic           match
);
    localparam int NPTR    = 2;
    localparam int SRC_IDX = 0;
    localparam int DST_IDX = 1;

    typedef struct packed {
        blkx_state_e                st;
        logic [NPTR-1:0][AW-1:0]    ptr;
        logic [CW-1:0]              cnt;
        logic [DW-1:0]              key;
        logic [DW-1:0]              data;
        blkx_op_t                   mode;
        logic                       match;
        logic                       done;
    } eng_t;

    eng_t                    eng_d, eng_q;
    blkx_op_t                dec_op;
    logic [NPTR-1:0][AW-1:0] ptr_nx;
    logic [CW-1:0]           cnt_nx;
    logic                    step;
    logic                    hit;

    blkx_decode #(.OPW(OPW)) dec_i (.op_code(op_code), .op(dec_op));

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        blkx_step #(.W(AW)) ptr_step_i (
            .val (eng_q.ptr[g]),
            .down(eng_q.mode.down),
            .nxt (ptr_nx[g])
        );
    end

    blkx_step #(.W(CW)) cnt_step_i (
        .val (eng_q.cnt),
        .down(1'b1),
        .nxt (cnt_nx)
    );

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        step       = 1'b0;
        hit        = (mem_rdata == eng_q.key);
        unique case (eng_q.st)
            ST_IDLE: begin
                if (start && dec_op.valid) begin
                    eng_d.st           = ST_READ;
                    eng_d.ptr[SRC_IDX] = src_init;
                    eng_d.ptr[DST_IDX] = dst_init;
                    eng_d.cnt          = cnt_init;
                    eng_d.key          = key;
                    eng_d.mode         = dec_op;
                    eng_d.match        = 1'b0;
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    if (eng_q.mode.cmp) begin
                        step               = 1'b1;
                        eng_d.ptr[SRC_IDX] = ptr_nx[SRC_IDX];
                        eng_d.cnt          = cnt_nx;
                        eng_d.match        = hit;
                        if (eng_q.mode.rpt && (cnt_nx != '0) && !hit) begin
                            eng_d.st = ST_READ;
                        end else begin
                            eng_d.st   = ST_IDLE;
                            eng_d.done = 1'b1;
                        end
                    end else begin
                        eng_d.data = mem_rdata;
                        eng_d.st   = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                if (mem_ack) begin
                    step      = 1'b1;
                    eng_d.ptr = ptr_nx;
                    eng_d.cnt = cnt_nx;
                    if (eng_q.mode.rpt && (cnt_nx != '0)) begin
                        eng_d.st = ST_READ;
                    end else begin
                        eng_d.st   = ST_IDLE;
                        eng_d.done = 1'b1;
                    end
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign mem_req   = (eng_q.st != ST_IDLE);
    assign mem_we    = (eng_q.st == ST_WRITE);
    assign mem_addr  = (eng_q.st == ST_WRITE) ? eng_q.ptr[DST_IDX] : eng_q.ptr[SRC_IDX];
    assign mem_wdata = eng_q.data;
    assign busy      = (eng_q.st != ST_IDLE);
    assign done      = eng_q.done;
    assign src_out   = eng_q.ptr[SRC_IDX];
    assign dst_out   = eng_q.ptr[DST_IDX];
    assign cnt_out   = eng_q.cnt;
    assign cnt_nz    = (eng_q.cnt != '0);
    assign match     = eng_q.match;

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (cnt_out == $past(cnt_out) - CW'(1)));
    // R4
    src_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !eng_q.mode.down) |=> (src_out == $past(src_out) + AW'(1)));
    // R4
    src_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && eng_q.mode.down) |=> (src_out == $past(src_out) - AW'(1)));
    // R5
    cmp_dst_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && eng_q.mode.cmp) |=> $stable(dst_out));
    // R3
    move_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !mem_we && !eng_q.mode.cmp) |=>
            (mem_req && mem_we && (mem_addr == dst_out) && (mem_wdata == $past(mem_rdata))));
    // R8
    hit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && eng_q.mode.cmp && hit) |=> (!busy && match));
    // R6
    single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !eng_q.mode.rpt) |=> !busy);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    // R2
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !dec_op.valid) |=> !busy);
    // R10
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
endmodule

// File: tb/blkx_engine_tb.sv
`timescale 1ns/1ps
module blkx_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op_code = '0;
    logic [15:0] src_init = '0, dst_init = '0, cnt_init = '0;
    logic [7:0]  key = '0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ack;
    logic        mem_req, mem_we, busy, done, cnt_nz, match;
    logic [15:0] mem_addr, src_out, dst_out, cnt_out;
    logic [7:0]  mem_wdata;

    int checks = 0;
    int errors = 0;
    logic ack_en = 1'b0;
    logic fast = 1'b0;
    logic const_mode = 1'b0;
    int rd_cnt = 0, wr_cnt = 0;

    logic [7:0] mem_w [int];
    logic [7:0] exp_mem [int];
    logic [15:0] e_src, e_dst, e_cnt;
    logic        e_match;
    int          e_rd, e_wr;

    always #2 clk = ~clk;

    blkx_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
        .src_init(src_init), .dst_init(dst_init), .cnt_init(cnt_init), .key(key),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done),
        .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out),
        .cnt_nz(cnt_nz), .match(match)
    );

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] bench_rd(input logic [15:0] a);
        if (const_mode) return 8'h00;
        if (mem_w.exists(int'(a))) return mem_w[int'(a)];
        return pat(a);
    endfunction

    function automatic logic [7:0] model_rd(input logic [15:0] a);
        if (const_mode) return 8'h00;
        if (exp_mem.exists(int'(a))) return exp_mem[int'(a)];
        return pat(a);
    endfunction

    assign mem_ack = mem_req & ack_en;

    always @(negedge clk) begin
        ack_en    <= fast ? 1'b1 : (($urandom % 4) != 0);
        mem_rdata <= bench_rd(mem_addr);
    end

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ack) begin
            if (mem_we) begin
                mem_w[int'(mem_addr)] = mem_wdata;
                wr_cnt++;
            end else begin
                rd_cnt++;
            end
        end
    end

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic model(input logic [7:0] op, input logic [15:0] s, input logic [15:0] d,
                         input logic [15:0] c, input logic [7:0] k);
        logic [7:0] b;
        e_match = 1'b0; e_rd = 0; e_wr = 0;
        do begin
            b = model_rd(s);
            e_rd++;
            if (!op[0]) begin
                exp_mem[int'(d)] = b;
                e_wr++;
                d = op[3] ? d - 16'd1 : d + 16'd1;
            end else begin
                e_match = (b == k);
            end
            s = op[3] ? s - 16'd1 : s + 16'd1;
            c = c - 16'd1;
        end while (op[4] && (c != 16'd0) && !(op[0] && e_match));
        e_src = s; e_dst = d; e_cnt = c;
    endtask

    task automatic launch(input logic [7:0] op, input logic [15:0] s, input logic [15:0] d,
                          input logic [15:0] c, input logic [7:0] k);
        exp_mem = mem_w;
        model(op, s, d, c, k);
        rd_cnt = 0; wr_cnt = 0;
        @(negedge clk);
        op_code = op; src_init = s; dst_init = d; cnt_init = c; key = k; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_op(input string tag, input logic [7:0] op);
        int t = 0;
        int bad = 0;
        while (!done && t < 70000) begin
            @(negedge clk);
            t++;
        end
        check("R10", {tag, " done seen"}, {31'd0, done}, 32'd1);
        check("R10", {tag, " busy low with done"}, {31'd0, busy}, 32'd0);
        check("R4", {tag, " src"}, {16'd0, src_out}, {16'd0, e_src});
        check("R4", {tag, " dst"}, {16'd0, dst_out}, {16'd0, e_dst});
        check("R4", {tag, " cnt"}, {16'd0, cnt_out}, {16'd0, e_cnt});
        check("R10", {tag, " cnt_nz"}, {31'd0, cnt_nz}, {31'd0, e_cnt != 16'd0});
        check("R5", {tag, " match"}, {31'd0, match}, {31'd0, e_match});
        check(op[4] ? "R7" : "R6", {tag, " reads"}, rd_cnt, e_rd);
        check("R3", {tag, " writes"}, wr_cnt, e_wr);
        foreach (exp_mem[a]) begin
            if (!mem_w.exists(a) || mem_w[a] !== exp_mem[a]) bad++;
        end
        if (mem_w.num() != exp_mem.num()) bad++;
        check("R3", {tag, " memory image"}, bad, 0);
        @(negedge clk);
        check("R10", {tag, " done one cycle"}, {31'd0, done}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] ops [8];
        logic [15:0] hold;
        void'($urandom(32'h1BADB002));
        ops = '{8'hA0, 8'hA8, 8'hB0, 8'hB8, 8'hA1, 8'hA9, 8'hB1, 8'hB9};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11", "busy", {31'd0, busy}, 0);
        check("R11", "done", {31'd0, done}, 0);
        check("R11", "mem_req", {31'd0, mem_req}, 0);
        check("R11", "match", {31'd0, match}, 0);
        check("R11", "regs", {src_out, cnt_out}, 0);
        check("R11", "dst", {16'd0, dst_out}, 0);

        // R6 R3 single copy upward
        launch(8'hA0, 16'h1000, 16'h3000, 16'd5, 8'h00);
        finish_op("R6 copy up", 8'hA0);
        check("R3", "copied byte", {24'd0, mem_w[int'(16'h3000)]}, {24'd0, pat(16'h1000)});
        // single copy downward
        launch(8'hA8, 16'h1000, 16'h3000, 16'd1, 8'h00);
        finish_op("R4 copy down", 8'hA8);
        check("R4", "down src", {16'd0, src_out}, 32'h0FFF);
        // R5 single search
        launch(8'hA1, 16'h2010, 16'h7777, 16'd3, pat(16'h2010));
        finish_op("R5 search", 8'hA1);
        check("R5", "dst untouched", {16'd0, dst_out}, 32'h7777);
        check("R5", "hit", {31'd0, match}, 1);
        // R7 repeat copy, overlapping downward
        launch(8'hB8, 16'h4010, 16'h4014, 16'd12, 8'h00);
        finish_op("R7 copy rep down", 8'hB8);
        // R8 repeat search early stop
        launch(8'hB1, 16'h2010, 16'h0000, 16'd10, pat(16'h2013));
        finish_op("R8 search stop", 8'hB1);
        check("R8", "stop cnt", {16'd0, cnt_out}, 32'd6);
        check("R8", "stop src", {16'd0, src_out}, 32'h2014);
        // R8 miss: repeat search down runs out
        launch(8'hB9, 16'h2050, 16'h0000, 16'd8, 8'hFF ^ 8'h5A ^ 8'h20);
        finish_op("R8 search miss", 8'hB9);

        // R2 invalid codes ignored
        hold = src_out;
        foreach (ops[i]) begin end
        @(negedge clk);
        op_code = 8'hA2; src_init = 16'hDEAD; cnt_init = 16'd4; start = 1'b1;
        @(negedge clk);
        op_code = 8'h30;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check("R2", "bad code busy", {31'd0, busy}, 0);
        check("R2", "bad code src kept", {16'd0, src_out}, {16'd0, hold});
        check("R2", "bad code no access", rd_cnt + wr_cnt, e_rd + e_wr);

        // R1 start while busy ignored
        launch(8'hB0, 16'h5000, 16'h6000, 16'd20, 8'h00);
        repeat (5) @(negedge clk);
        check("R1", "busy after start", {31'd0, busy}, 1);
        op_code = 8'hA1; src_init = 16'h0100; cnt_init = 16'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_op("R1 restart ignored", 8'hB0);

        // random operations with stalls
        for (int n = 0; n < 40; n++) begin
            logic [7:0] op;
            logic [15:0] s, d, c;
            logic [7:0] k;
            op = ops[$urandom % 8];
            s = 16'($urandom);
            d = 16'($urandom);
            c = 16'(1 + ($urandom % 24));
            k = (($urandom % 2) == 0) ? pat(s + 16'(op[3] ? -($urandom % 8) : ($urandom % 8))) : 16'($urandom);
            launch(op, s, d, c, k);
            finish_op("R4 random", op);
        end

        // R7 zero count wraps to 65536 bytes
        fast = 1'b1;
        const_mode = 1'b1;
        launch(8'hB1, 16'h1234, 16'h0000, 16'd0, 8'hFF);
        finish_op("R7 wrap", 8'hB1);
        check("R7", "wrap reads", rd_cnt, 65536);
        const_mode = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule